// File: doc/BRIEF.md
# Cartridge Bank Mapper with Bit-Banged Serial Port

This block sits on a 16-bit cartridge bus and turns a host word address into a ROM word address. The first 2.5 MB of the space goes straight through to ROM. The 1.5 MB above it is three 512 KB windows. Each window takes its upper address bits from its own 4-bit bank register, so any 512 KB page of an 8 MB ROM can appear in any window.

A small register space holds the three bank registers and a serial port. Software toggles the port's four output pins to bit-bang a serial EEPROM, and it reads the EEPROM's data-out pin back through one register.

One fixed pair of ROM words acts as a copy-protection probe. For the first six strobed reads of that pair, it returns a short value. After that it returns the long value.

Top module: `cart_mapper`

## Requirements
- R1: A cartridge read at a word address below 0x140000 (byte 0x280000) drives `rom_waddr` equal to the word address, with bit 21 zero.
- R2: A word address in 0x140000..0x1FFFFF selects window n = address[20:18] - 5. `rom_waddr` is then {bank register n, address[17:0]}, so the ROM byte address is the in-window offset plus bank × 0x80000.
- R3: A register write at word offset 1, 2 or 3 (byte offsets 2, 4, 6) loads bank register 0, 1 or 2 from `wr_data[3:0]`. Higher data bits are dropped.
- R4: A register write at word offset 4 (byte offset 8) drives `ser_si` from data bit 0, `ser_sck` from bit 1, `ser_hold` from bit 2 and `ser_cs` from bit 3, starting the cycle after the write edge.
- R5: The serial pins are registered and keep their value until the next write at word offset 4. Writes at any other offset leave them unchanged.
- R6: A register read at word offset 5 (byte offset 0x0A) returns {15'b0, `ser_so`} on `rd_data`. A register read at any other offset returns 0xFFFF. A register read takes priority over a cartridge read.
- R7: A cartridge read of word 0xAF3 (byte 0x15E6) or word 0xAF4 (byte 0x15E8) returns 0x0000 or 0x0010 respectively while fewer than 6 such reads have completed. Both addresses share one count.
- R8: From the 7th such read on, the same addresses return 0x0001 and 0x8010. The count saturates at 6.
- R9: The protection count advances only on a clock edge where `cart_rd` is high at a protection address. Idle cycles and reads of other addresses do not advance it.
- R10: Active-low reset `rst_n` clears all three bank registers, the protection count and the four serial pins.
- R11: A register write at word offset 0 changes neither the mapping nor the serial pins.
- R12: For any other cartridge read, `rd_data` equals `rom_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cart_rd | input | 1 | Cartridge read strobe, one per clocked read |
| cart_waddr | input | 21 | Cartridge word address |
| rom_q | input | 16 | Word returned by the ROM for `rom_waddr` |
| reg_rd | input | 1 | Register-space read strobe |
| reg_wr | input | 1 | Register-space write strobe |
| reg_woff | input | 7 | Register word offset |
| wr_data | input | 16 | Register write data |
| ser_so | input | 1 | Serial data out from the EEPROM |
| rom_waddr | output | 22 | Mapped ROM word address |
| rd_data | output | 16 | Read data to the host |
| ser_si | output | 1 | Serial data in to the EEPROM |
| ser_sck | output | 1 | Serial clock |
| ser_hold | output | 1 | Hold line |
| ser_cs | output | 1 | Chip select line |

## Verification
The bench checks the window edges: the last direct word, the first word of window 0, and the last word of window 2 with bank 15. A design that is off by one on the window base or the subtraction would map one of these into the wrong page.

It holds a protection address on the bus for idle cycles before reading it, and it reads past the sixth probe. A counter that counts bus cycles, or one that wraps, would switch to the long value too early or fall back to the short one.

It writes offsets 0 and 5 between two port writes. It also reads bank and port offsets. This catches port bits that follow any write, and register reads that leak bank data instead of 0xFFFF.

// File: rtl/cart_pkg.sv
package cart_pkg;
    parameter int WADDR_W   = 21;
    parameter int BANK_W    = 4;
    parameter int N_WIN     = 3;
    parameter int WIN_OFS_W = 18;
    parameter int ROM_W     = BANK_W + WIN_OFS_W;
    parameter int DATA_W    = 16;
    parameter int REG_W     = 7;
    parameter int SER_W     = 4;
    parameter int PROT_LIM  = 6;
    parameter int CNT_W     = $clog2(PROT_LIM + 1);

    localparam logic [WADDR_W-1:0] UPPER_BASE = 21'h140000;
    localparam logic [WADDR_W-1:0] PROT_A     = 21'h000AF3;
    localparam logic [WADDR_W-1:0] PROT_B     = 21'h000AF4;

    localparam logic [REG_W-1:0] OFF_PORT  = 7'd4;
    localparam logic [REG_W-1:0] OFF_SO    = 7'd5;
    localparam logic [REG_W-1:0] OFF_BANK0 = 7'd1;

    typedef logic [N_WIN-1:0][BANK_W-1:0] bank_vec_t;
endpackage

// File: rtl/cart_addr_map.sv
module cart_addr_map
    import cart_pkg::*;
(
    input  logic [WADDR_W-1:0] waddr,
    input  bank_vec_t          banks,
    output logic [ROM_W-1:0]   rom_waddr,
    output logic               is_upper
);
    localparam int WIN_SEL_W = WADDR_W - WIN_OFS_W;
    localparam logic [WIN_SEL_W-1:0] BASE_IDX = UPPER_BASE[WADDR_W-1:WIN_OFS_W];

    logic [WIN_SEL_W-1:0] win_idx;
    logic [BANK_W-1:0]    bank_sel;

    always_comb begin
        is_upper = (waddr >= UPPER_BASE);
        win_idx  = waddr[WADDR_W-1:WIN_OFS_W] - BASE_IDX;
        bank_sel = '0;
        for (int n = 0; n < N_WIN; n++) begin
            if (win_idx == WIN_SEL_W'(n)) bank_sel = banks[n];
        end
        if (is_upper) rom_waddr = {bank_sel, waddr[WIN_OFS_W-1:0]};
        else          rom_waddr = ROM_W'(waddr);
    end
endmodule

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs
    import cart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_woff,
    input  logic [DATA_W-1:0] wr_data,
    output bank_vec_t         banks,
    output logic [SER_W-1:0]  port
);
    typedef struct packed {
        bank_vec_t        bank;
        logic [SER_W-1:0] port;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            for (int n = 0; n < N_WIN; n++) begin
                if (reg_woff == OFF_BANK0 + REG_W'(n)) st_d.bank[n] = wr_data[BANK_W-1:0];
            end
            if (reg_woff == OFF_PORT) st_d.port = wr_data[SER_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign banks = st_q.bank;
    assign port  = st_q.port;

    // R5: pins move only after a port write
    p_port_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_woff == OFF_PORT) |=> $stable(port));

    // R3, R11: bank registers move only after a bank-offset write
    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_woff >= OFF_BANK0 && reg_woff < OFF_BANK0 + REG_W'(N_WIN)) |=> $stable(banks));
endmodule

// File: rtl/cart_protect.sv
module cart_protect
    import cart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cart_rd,
    input  logic [WADDR_W-1:0] waddr,
    output logic              hit,
    output logic [DATA_W-1:0] resp
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } prot_t;

    prot_t st_d, st_q;
    logic  early;

    always_comb begin
        hit   = (waddr == PROT_A) || (waddr == PROT_B);
        early = (st_q.cnt < CNT_W'(PROT_LIM));
        if (waddr == PROT_A) resp = early ? 16'h0000 : 16'h0001;
        else                 resp = early ? 16'h0010 : 16'h8010;
        st_d = st_q;
        if (cart_rd && hit && early) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(PROT_LIM));

    p_cnt_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cart_rd && hit) |=> $stable(st_q.cnt));
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cart_rd,
    input  logic [20:0]         cart_waddr,
    input  logic [15:0]         rom_q,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [6:0]          reg_woff,
    input  logic [15:0]         wr_data,
    input  logic                ser_so,
    output logic [21:0]         rom_waddr,
    output logic [15:0]         rd_data,
    output logic                ser_si,
    output logic                ser_sck,
    output logic                ser_hold,
    output logic                ser_cs
);
    bank_vec_t         banks;
    logic [SER_W-1:0]  port;
    logic              is_upper;
    logic              prot_hit;
    logic [DATA_W-1:0] prot_resp;

    cart_addr_map u_map (
        .waddr     (cart_waddr),
        .banks     (banks),
        .rom_waddr (rom_waddr),
        .is_upper  (is_upper)
    );

    cart_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_woff (reg_woff),
        .wr_data  (wr_data),
        .banks    (banks),
        .port     (port)
    );

    cart_protect u_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .cart_rd (cart_rd),
        .waddr   (cart_waddr),
        .hit     (prot_hit),
        .resp    (prot_resp)
    );

    always_comb begin
        if (reg_rd)        rd_data = (reg_woff == OFF_SO) ? {15'b0, ser_so} : 16'hFFFF;
        else if (prot_hit) rd_data = prot_resp;
        else               rd_data = rom_q;
    end

    assign {ser_cs, ser_hold, ser_sck, ser_si} = port;

    p_low_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_rd && !is_upper) |-> (rom_waddr[21] == 1'b0 && rom_waddr[20:0] == cart_waddr));

    p_reg_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_woff != OFF_SO) |-> rd_data == 16'hFFFF);

    p_reset_pins_r10: assert property (@(posedge clk)
        !rst_n |=> ({ser_cs, ser_hold, ser_sck, ser_si} == 4'b0000));
endmodule

// File: tb/cart_mapper_tb.sv
module cart_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cart_rd = 1'b0;
    logic [20:0] cart_waddr = '0;
    logic [15:0] rom_q = 16'h1234;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_woff = '0;
    logic [15:0] wr_data = '0;
    logic        ser_so = 1'b0;
    logic [21:0] rom_waddr;
    logic [15:0] rd_data;
    logic        ser_si, ser_sck, ser_hold, ser_cs;

    always #2 clk = ~clk;

    cart_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cart_rd(cart_rd), .cart_waddr(cart_waddr),
        .rom_q(rom_q), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_woff(reg_woff),
        .wr_data(wr_data), .ser_so(ser_so), .rom_waddr(rom_waddr), .rd_data(rd_data),
        .ser_si(ser_si), .ser_sck(ser_sck), .ser_hold(ser_hold), .ser_cs(ser_cs)
    );

    typedef struct {
        int          kind;   // 0 rom_waddr, 1 rd_data, 2 serial pins {cs,hold,sck,si}
        logic [21:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic expect_item(int kind, logic [21:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [21:0] got;
                it = q.pop_front();
                case (it.kind)
                    0:       got = rom_waddr;
                    1:       got = {6'b0, rd_data};
                    default: got = {18'b0, ser_cs, ser_hold, ser_sck, ser_si};
                endcase
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic cart_read(logic [20:0] a, int kind, logic [21:0] exp, string req);
        @(posedge clk); #1;
        cart_rd = 1'b1; cart_waddr = a;
        expect_item(kind, exp, req);
        @(posedge clk); #1;
        cart_rd = 1'b0;
    endtask

    task automatic reg_write(logic [6:0] off, logic [15:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_woff = off; wr_data = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [6:0] off, logic [15:0] exp, string req);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_woff = off;
        expect_item(1, {6'b0, exp}, req);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic check_pins(logic [3:0] exp, string req);
        @(posedge clk); #1;
        expect_item(2, {18'b0, exp}, req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: reset state
        cart_read(21'h140000, 0, 22'h000000, "R10 bank0 after reset");
        check_pins(4'b0000, "R10 pins after reset");
        // R1: direct region incl. last word
        cart_read(21'h000123, 0, 22'h000123, "R1 low map");
        cart_read(21'h13FFFF, 0, 22'h13FFFF, "R1 last direct word");
        cart_read(21'h000200, 1, 22'h001234, "R12 rom data pass-through");
        // R3 / R2: bank loads and window mapping
        reg_write(7'd1, 16'hFFA5);
        reg_write(7'd2, 16'h0003);
        reg_write(7'd3, 16'h000F);
        cart_read(21'h140010, 0, 22'h140010, "R2 R3 window0 bank5");
        cart_read(21'h180020, 0, 22'h0C0020, "R2 R3 window1 bank3");
        cart_read(21'h1FFFFF, 0, 22'h3FFFFF, "R2 R3 window2 bank15 last");
        // R11: offset 0 write has no effect
        reg_write(7'd0, 16'hFFFF);
        cart_read(21'h140010, 0, 22'h140010, "R11 mapping after off0 write");
        check_pins(4'b0000, "R11 pins after off0 write");
        // R4 / R5: serial port
        reg_write(7'd4, 16'h000A);
        check_pins(4'b1010, "R4 port write");
        reg_write(7'd5, 16'h000F);
        reg_write(7'd0, 16'h0005);
        check_pins(4'b1010, "R5 port held");
        reg_write(7'd4, 16'hFFF5);
        check_pins(4'b0101, "R4 second port write");
        // R6: register reads
        ser_so = 1'b1;
        reg_read(7'd5, 16'h0001, "R6 so high");
        ser_so = 1'b0;
        reg_read(7'd5, 16'h0000, "R6 so low");
        reg_read(7'd1, 16'hFFFF, "R6 bank offset read");
        reg_read(7'd4, 16'hFFFF, "R6 port offset read");
        // R9: idle cycles at the probe address do not count
        @(posedge clk); #1 cart_waddr = 21'h000AF3;
        repeat (8) @(posedge clk);
        cart_read(21'h000100, 1, 22'h001234, "R12 other read");
        // R7: first six probe reads
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) cart_read(21'h000AF3, 1, 22'h000000, "R7 R9 early A");
            else            cart_read(21'h000AF4, 1, 22'h000010, "R7 R9 early B");
        end
        // R8: later reads, saturating
        for (int i = 0; i < 10; i++) begin
            if (i % 2 == 0) cart_read(21'h000AF3, 1, 22'h000001, "R8 late A");
            else            cart_read(21'h000AF4, 1, 22'h008010, "R8 late B");
        end
        // R10: reset mid-run
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        cart_read(21'h000AF3, 1, 22'h000000, "R10 counter cleared");
        cart_read(21'h140010, 0, 22'h000010, "R10 bank cleared");
        check_pins(4'b0000, "R10 pins cleared");
        repeat (3) @(posedge clk);
        done = 1;
        summary();
    end
endmodule